// File: doc/BRIEF.md
# Latency-hiding warp issue scheduler

This block picks, on every clock cycle, at most one warp to issue from a pool of resident warps. A warp that has started a long-latency operation and still has a result outstanding is not eligible to issue. While it waits, any other resident warp that has no outstanding result and is not held at a barrier can issue in its place. This keeps the execution slot busy while memory traffic is in flight.

Long-latency units report through two single-entry strobes. The increment strobe is raised in the cycle a warp launches an operation whose result it will need. The decrement strobe is raised when such a result returns. A tracker instance for each warp holds the count of outstanding results. The tracker has two named states. `PS_CLEAR` means the count is zero. `PS_WAITING` means the count is non-zero. The transition `go_wait` (an increment with no matching decrement, taken from `PS_CLEAR`) moves a tracker into `PS_WAITING`. The transition `go_clear` (a decrement with no matching increment, taken when the count is one) moves it back to `PS_CLEAR`. In every other case the tracker keeps its state.

Eligible warps go to a round-robin arbiter. The arbiter starts its search at the warp after the last warp it issued.

Top module: `lhs_warp_issue`

## Requirements
- R1: After reset every pending count is zero and the last-issued pointer is warp NUM_WARPS-1. The first search therefore starts at warp 0.
- R2: A warp is ready only when all three of these hold: its `resident_mask` bit is 1, its `barrier_hold` bit is 0, and its pending count is zero.
- R3: `issue_vld` is 1 in exactly those cycles in which at least one warp is ready. `issue_id` then names one ready warp. Both outputs depend combinationally on the current inputs and the current state.
- R4: When several warps are ready, the pick is the first ready warp found by scanning upward from the last issued warp plus one, wrapping modulo NUM_WARPS. After a cycle with `issue_vld`=1, the pointer becomes that cycle's `issue_id`.
- R5: In a cycle with no ready warp, `issue_vld` is 0 and the pointer keeps its value.
- R6: An increment (`pend_inc_vld`=1 with id w) alone raises warp w's count by one at the clock edge. Warp w is then not ready in the next cycle.
- R7: A decrement (`pend_dec_vld`=1 with id w) alone lowers warp w's count by one at the clock edge. Warp w becomes eligible again once its count reaches zero.
- R8: An increment and a decrement naming the same warp in the same cycle leave that warp's count unchanged.
- R9: A decrement to a warp whose count is zero is ignored. An increment to a warp whose count is at its maximum (2^PEND_W-1) is ignored.
- R10: An increment and a decrement naming different warps in the same cycle both take effect.
- R11: While `issue_vld` is 0, `issue_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| resident_mask | input | NUM_WARPS | Bit w is 1 when warp w is resident |
| barrier_hold | input | NUM_WARPS | Bit w is 1 when warp w waits at a barrier |
| pend_inc_vld | input | 1 | A long-latency operation with a needed result is launched |
| pend_inc_id | input | $clog2(NUM_WARPS) | Warp launching that operation |
| pend_dec_vld | input | 1 | A long-latency result returns |
| pend_dec_id | input | $clog2(NUM_WARPS) | Warp receiving that result |
| issue_vld | output | 1 | A warp is issued this cycle |
| issue_id | output | $clog2(NUM_WARPS) | Index of the issued warp, 0 when none |

## Verification
The bench sweeps every resident mask against a varying barrier pattern and checks round-robin wraparound from every pointer position. A scheduler with an off-by-one start would re-issue the same warp, and one that lost the pointer would restart at warp 0. Directed runs check the cases where the counter matters. A same-cycle increment and decrement on one warp must leave it waiting; a faulty design would release it early or strand it. An eighth increment at a full three-bit count must be dropped; a wrapping counter would let the warp issue while results are still outstanding. A long pseudo-random run of mixed strobes is then compared against the bench's own arithmetic model of every count.

// File: rtl/lhs_pkg.sv
package lhs_pkg;

    typedef enum logic {
        PS_CLEAR   = 1'b0,
        PS_WAITING = 1'b1
    } pend_state_e;

endpackage

// File: rtl/lhs_pend_tracker.sv
module lhs_pend_tracker
    import lhs_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [PEND_W-1:0] cnt_o,
    output logic              clear_o
);

    localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] CNT_ONE = PEND_W'(1);

    pend_state_e       state_q, state_d;
    logic [PEND_W-1:0] cnt_q, cnt_d;
    logic              inc_only, dec_only;

    assign inc_only = inc_i && !dec_i;
    assign dec_only = dec_i && !inc_i;

    // next count: saturating up, floored down, unchanged on a collision
    always_comb begin
        cnt_d = cnt_q;
        if (inc_only && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_ONE;
        end else if (dec_only && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    // transitions go_wait / go_clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_CLEAR: begin
                if (inc_only) begin
                    state_d = PS_WAITING;
                end
            end
            PS_WAITING: begin
                if (dec_only && cnt_q == CNT_ONE) begin
                    state_d = PS_CLEAR;
                end
            end
            default: state_d = PS_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cnt_o   = cnt_q;
        clear_o = 1'b0;
        unique case (state_q)
            PS_CLEAR:   clear_o = 1'b1;
            PS_WAITING: clear_o = 1'b0;
            default:    clear_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lhs_rr_arbiter.sv
module lhs_rr_arbiter #(
    parameter int NUM_WARPS = 8,
    parameter int ID_W      = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] ready_i,
    output logic                 grant_vld_o,
    output logic [ID_W-1:0]      grant_id_o,
    output logic [ID_W-1:0]      last_id_o
);

    localparam logic [ID_W-1:0] LAST_RESET = ID_W'(NUM_WARPS - 1);

    logic [ID_W-1:0] last_q;
    logic [ID_W-1:0] pick;
    logic            found;

    // scan from last_q+1 upward, wrapping
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            logic [ID_W-1:0] cand;
            cand = ID_W'((int'(last_q) + k) % NUM_WARPS);
            if (!found && ready_i[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_RESET;
        end else if (found) begin
            last_q <= pick;
        end
    end

    assign grant_vld_o = found;
    assign grant_id_o  = pick;
    assign last_id_o   = last_q;

endmodule

// File: rtl/lhs_warp_issue.sv
module lhs_warp_issue #(
    parameter int NUM_WARPS = 8,
    parameter int PEND_W    = 3,
    parameter int ID_W      = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] resident_mask,
    input  logic [NUM_WARPS-1:0] barrier_hold,
    input  logic                 pend_inc_vld,
    input  logic [ID_W-1:0]      pend_inc_id,
    input  logic                 pend_dec_vld,
    input  logic [ID_W-1:0]      pend_dec_id,
    output logic                 issue_vld,
    output logic [ID_W-1:0]      issue_id
);

    localparam int CNT_BITS = NUM_WARPS * PEND_W;

    logic [NUM_WARPS-1:0] inc_hit;
    logic [NUM_WARPS-1:0] dec_hit;
    logic [NUM_WARPS-1:0] clear_vec;
    logic [NUM_WARPS-1:0] ready_vec;
    logic [CNT_BITS-1:0]  pend_cnt_flat;
    logic [ID_W-1:0]      last_id;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign inc_hit[w] = pend_inc_vld && (pend_inc_id == ID_W'(w));
        assign dec_hit[w] = pend_dec_vld && (pend_dec_id == ID_W'(w));

        lhs_pend_tracker #(
            .PEND_W (PEND_W)
        ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc_hit[w]),
            .dec_i   (dec_hit[w]),
            .cnt_o   (pend_cnt_flat[w*PEND_W +: PEND_W]),
            .clear_o (clear_vec[w])
        );

        assign ready_vec[w] = resident_mask[w] && !barrier_hold[w] && clear_vec[w];
    end

    lhs_rr_arbiter #(
        .NUM_WARPS (NUM_WARPS),
        .ID_W      (ID_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready_vec),
        .grant_vld_o (issue_vld),
        .grant_id_o  (issue_id),
        .last_id_o   (last_id)
    );

endmodule

// File: rtl/lhs_warp_issue_checker.sv
module lhs_warp_issue_checker #(
    parameter int NUM_WARPS = 8,
    parameter int PEND_W    = 3,
    parameter int ID_W      = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_WARPS-1:0]          resident_mask,
    input logic [NUM_WARPS-1:0]          barrier_hold,
    input logic                          pend_inc_vld,
    input logic [ID_W-1:0]               pend_inc_id,
    input logic                          pend_dec_vld,
    input logic [ID_W-1:0]               pend_dec_id,
    input logic                          issue_vld,
    input logic [ID_W-1:0]               issue_id,
    input logic [ID_W-1:0]               last_id,
    input logic [NUM_WARPS*PEND_W-1:0]   pend_cnt_flat
);

    assert_issue_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (resident_mask[issue_id] && !barrier_hold[issue_id]
                       && pend_cnt_flat[issue_id*PEND_W +: PEND_W] == '0));

    assert_ptr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> (last_id == $past(issue_id)));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> $stable(last_id));

    assert_inc_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_inc_vld && !(pend_dec_vld && pend_dec_id == pend_inc_id))
        |=> !(issue_vld && issue_id == $past(pend_inc_id)));

    assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_inc_vld && pend_dec_vld && pend_inc_id == pend_dec_id)
        |=> (pend_cnt_flat[$past(pend_inc_id)*PEND_W +: PEND_W]
             == $past(pend_cnt_flat[pend_inc_id*PEND_W +: PEND_W])));

    assert_idle_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |-> (issue_id == '0));

endmodule

bind lhs_warp_issue lhs_warp_issue_checker #(
    .NUM_WARPS (NUM_WARPS),
    .PEND_W    (PEND_W),
    .ID_W      (ID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .resident_mask (resident_mask),
    .barrier_hold  (barrier_hold),
    .pend_inc_vld  (pend_inc_vld),
    .pend_inc_id   (pend_inc_id),
    .pend_dec_vld  (pend_dec_vld),
    .pend_dec_id   (pend_dec_id),
    .issue_vld     (issue_vld),
    .issue_id      (issue_id),
    .last_id       (last_id),
    .pend_cnt_flat (pend_cnt_flat)
);

// File: tb/lhs_warp_issue_bench.sv
module lhs_warp_issue_bench;

    localparam int NW   = 8;
    localparam int PW   = 3;
    localparam int IW   = 3;
    localparam int CMAX = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] resident_mask = '0;
    logic [NW-1:0] barrier_hold = '0;
    logic          pend_inc_vld = 1'b0;
    logic [IW-1:0] pend_inc_id = '0;
    logic          pend_dec_vld = 1'b0;
    logic [IW-1:0] pend_dec_id = '0;
    logic          issue_vld;
    logic [IW-1:0] issue_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_cnt [NW];
    int m_last;

    always #2 clk = ~clk;

    lhs_warp_issue #(.NUM_WARPS(NW), .PEND_W(PW)) u_lhs_warp_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .resident_mask (resident_mask),
        .barrier_hold  (barrier_hold),
        .pend_inc_vld  (pend_inc_vld),
        .pend_inc_id   (pend_inc_id),
        .pend_dec_vld  (pend_dec_vld),
        .pend_dec_id   (pend_dec_id),
        .issue_vld     (issue_vld),
        .issue_id      (issue_id)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check(input bit ev, input int eid, input string req);
        checks++;
        if (issue_vld !== ev || int'(issue_id) != eid) begin
            failures++;
            $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
                     req, issue_vld, issue_id, ev, eid);
        end
    endtask

    // one cycle: drive (already at negedge), compare, advance model, move to next negedge
    task automatic step(input logic [NW-1:0] res, input logic [NW-1:0] bar,
                        input bit iv, input int ii, input bit dv, input int di,
                        input string req);
        bit ev;
        int eid;
        resident_mask = res;
        barrier_hold  = bar;
        pend_inc_vld  = iv;
        pend_inc_id   = IW'(ii);
        pend_dec_vld  = dv;
        pend_dec_id   = IW'(di);
        #1;
        ev  = 1'b0;
        eid = 0;
        for (int k = 1; k <= NW; k++) begin
            int c;
            c = (m_last + k) % NW;
            if (!ev && res[c] && !bar[c] && m_cnt[c] == 0) begin
                ev  = 1'b1;
                eid = c;
            end
        end
        check(ev, eid, req);
        if (ev) m_last = eid;
        for (int w = 0; w < NW; w++) begin
            bit a, b;
            a = iv && ii == w;
            b = dv && di == w;
            if (a && !b && m_cnt[w] < CMAX) m_cnt[w]++;
            else if (b && !a && m_cnt[w] > 0) m_cnt[w]--;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got no finish, expected finish");
        report();
    end

    initial begin
        logic [15:0] lf;
        for (int w = 0; w < NW; w++) m_cnt[w] = 0;
        m_last = NW - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5 / R11: reset state, nothing resident
        step('0, '0, 0, 0, 0, 0, "R1 R5 R11 idle after reset");
        // R1 / R4: all resident, rotates 0..7 then wraps to 0
        for (int i = 0; i < NW + 2; i++)
            step('1, '0, 0, 0, 0, 0, "R1 R4 rotation");

        // R2 R3 R4 R5: sweep every resident mask against barrier patterns
        for (int m = 0; m < 256; m++)
            step(NW'(m), NW'(m * 37 + 5), 0, 0, 0, 0, "R2 R3 R4 R5 mask sweep");

        // R6: only warp 3 resident; launching on it blocks it next cycle
        step(8'h08, '0, 1, 3, 0, 0, "R6 inc launch");
        step(8'h08, '0, 0, 0, 0, 0, "R6 warp3 blocked");
        // R8: collision on warp 3 keeps it waiting
        step(8'h08, '0, 1, 3, 1, 3, "R8 collision");
        step(8'h08, '0, 0, 0, 0, 0, "R8 still waiting");
        // R7: return releases it
        step(8'h08, '0, 0, 0, 1, 3, "R7 return");
        step(8'h08, '0, 0, 0, 0, 0, "R7 warp3 ready again");
        // R9: decrement at zero ignored
        step(8'h08, '0, 0, 0, 1, 3, "R9 dec at zero");
        step(8'h08, '0, 0, 0, 0, 0, "R9 still ready");
        // R9: saturation at CMAX then CMAX returns clear it
        for (int i = 0; i < CMAX + 1; i++)
            step(8'h04, '0, 1, 2, 0, 0, "R9 inc to saturation");
        for (int i = 0; i < CMAX - 1; i++)
            step(8'h04, '0, 0, 0, 1, 2, "R9 draining");
        step(8'h04, '0, 0, 0, 0, 0, "R9 one result left");
        step(8'h04, '0, 0, 0, 1, 2, "R9 last return");
        step(8'h04, '0, 0, 0, 0, 0, "R9 ready after saturation");
        // R10: different warps in one cycle
        step(8'h22, '0, 1, 1, 0, 0, "R10 setup");
        step(8'h22, '0, 1, 5, 1, 1, "R10 split strobes");
        step(8'h22, '0, 0, 0, 0, 0, "R10 warp1 back warp5 waiting");

        // R6 R7 R8 R9 R10: pseudo-random mixed traffic
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(NW'(lf[7:0] | 8'h81), NW'(lf[15:8] & 8'h3C),
                 lf[0], int'(lf[3:1]), lf[4], (lf[9] ? int'(lf[3:1]) : int'(lf[12:10])),
                 "R6 R7 R8 R9 R10 mixed traffic");
        end

        report();
    end

endmodule